// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter

This block is a finite impulse response filter that forms its output without a single multiplier. Accepted samples move through a delay line of `TAPS` words. The filter then walks through the sample bit positions from least significant upward. At each position it gathers that bit from every tap into an address. The address reads tables that hold precomputed sums of coefficients. Each table result is weighted by its bit position and added into a full-precision accumulator. The taps are split into groups of `GROUP` taps, and each group has its own table of `2^GROUP` words. The group results are added before they are weighted.

The design is folded. One sample is taken every `RATIO` clock cycles, and `BPC` bit positions are handled in each of those cycles. The configuration is rejected at elaboration when `RATIO < 2` or when `RATIO*BPC < IN_W`. The `SIGNED` parameter chooses between all-unsigned arithmetic and all-two's-complement arithmetic for both the samples and the coefficients. The `FIXED_COEF` parameter chooses where the tables come from. When it is set, they are constant tables computed from the `COEFS` parameter. When it is clear, they are writable storage that is loaded through a table write port.

Top module: `dafir`

## Requirements
- R1: `outData` is `OUT_W = IN_W + COEF_W + ceil(log2(TAPS)) - 1` bits wide and equals the exact sum over k of c_k times x[n-k], taken over the TAPS newest accepted samples. No rounding or saturation is applied, and only the low OUT_W bits are kept.
- R2: With SIGNED=0, the samples and the coefficients are both treated as unsigned integers.
- R3: With SIGNED=1, the samples and the coefficients are both two's complement. The sample MSB carries the weight -2^(IN_W-1).
- R4: A sample is accepted when `inValid` is high while the filter is idle, or while it is in the last of its RATIO processing cycles. A high `inValid` at any other time is ignored: the delay line does not shift and no extra output appears.
- R5: `outValid` is high for exactly one cycle, RATIO clock edges after the edge that accepted the sample. `outData` holds its value at all other times.
- R6: Tap 0 holds the newest accepted sample and tap k holds the sample accepted k acceptances earlier. The delay line shifts only when a sample is accepted.
- R7: With FIXED_COEF=1, the tables are computed from `COEFS`, where tap k occupies bits [k*COEF_W +: COEF_W]. Writes on the table port have no effect on the output.
- R8: With FIXED_COEF=0, a high `wrEn` stores `wrData` into one table word on that clock edge. The upper GA_W bits of `wrAddr` pick the group and the lower GROUP bits pick the entry. Entry bit j stands for tap g*GROUP+j. The correct word for an entry is the sum of the coefficients of the taps whose bit is 1 in that entry.
- R9: There are ceil(TAPS/GROUP) group tables. They are read in parallel and their results are added for each bit position. BPC bit positions are consumed per cycle, starting at the least significant one.
- R10: While `rst` is high and after it falls, the taps are zero, `outValid` is low, `outData` is zero and the filter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe |
| inData | input | IN_W | Input sample |
| wrEn | input | 1 | Table word write strobe |
| wrAddr | input | GA_W+GROUP | Group index above the entry index |
| wrData | input | LUT_W | Table word to store |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | OUT_W | Full-precision filter output |

## Verification
Two filters run side by side. The first is signed, uses constant tables and takes two bits per cycle. The second is unsigned, uses written tables, takes one bit per cycle and has a last group that is only partly filled. Both are driven with the same stimulus, which runs through these patterns in turn:

- A single impulse shows each coefficient on its own, which proves the tap order and the table partitioning.
- Runs of full-scale values (0x80 and 0xFF) exercise the subtraction at the sign position and the largest sums in the accumulator.
- Holding `inValid` high without a break proves that extra strobes are ignored at both fold ratios.
- Random data with random strobe gaps mixes together idle acceptance, acceptance in the last cycle, and ignored strobes.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // accept a sample: shift taps, clear accumulator
    logic run;   // a bit-step is being processed this cycle
    logic done;  // final bit-step of the current sample
  } dafirStrobe_t;

endpackage

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
#(
  parameter int RATIO = 4,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output dafirStrobe_t     strobe,
  output logic [CNT_W-1:0] stepIdx
);

  logic busy;
  logic lastStep;
  logic accept;

  assign lastStep = busy && (stepIdx == CNT_W'(RATIO - 1));
  assign accept   = inValid && (!busy || lastStep);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      stepIdx <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      stepIdx <= '0;
    end else if (lastStep) begin
      busy    <= 1'b0;
      stepIdx <= '0;
    end else if (busy) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  always_comb begin
    strobe.load = accept;
    strobe.run  = busy;
    strobe.done = lastStep;
  end

endmodule

// File: rtl/dafir_lut.sv
module dafir_lut #(
  parameter int IN_W       = 8,
  parameter int COEF_W     = 8,
  parameter int TAPS       = 12,
  parameter int GROUP      = 8,
  parameter int BPC        = 2,
  parameter int SIGNED     = 1,
  parameter int FIXED_COEF = 1,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  localparam int NG    = (TAPS + GROUP - 1) / GROUP,
  localparam int GA_W  = (NG > 1) ? $clog2(NG) : 1,
  localparam int LUT_W = COEF_W + $clog2(GROUP + 1),
  localparam int ROWS  = 2 ** GA_W,
  localparam int WORDS = 2 ** GROUP
) (
  input  logic                  clk,
  input  logic                  wrEn,
  input  logic [GA_W+GROUP-1:0] wrAddr,
  input  logic [LUT_W-1:0]      wrData,
  input  logic [GROUP-1:0]      rdAddr [BPC][NG],
  output logic [LUT_W-1:0]      rdData [BPC][NG]
);

  logic [LUT_W-1:0] tbl [ROWS][WORDS];

  // Sum of the group's coefficients selected by the entry bits
  function automatic logic [LUT_W-1:0] entryVal(int g, int a);
    int s;
    int t;
    logic [COEF_W-1:0] c;
    s = 0;
    for (int j = 0; j < GROUP; j++) begin
      t = g * GROUP + j;
      if (t < TAPS && ((a >> j) & 1) == 1) begin
        c = COEFS[t*COEF_W +: COEF_W];
        if (SIGNED != 0) s += int'($signed(c));
        else             s += int'(c);
      end
    end
    return LUT_W'(s);
  endfunction

  generate
    if (FIXED_COEF != 0) begin : g_rom
      logic unusedWr;
      assign unusedWr = ^{clk, wrEn, wrAddr, wrData};
      always_comb begin
        for (int g = 0; g < ROWS; g++)
          for (int a = 0; a < WORDS; a++)
            tbl[g][a] = (g < NG) ? entryVal(g, a) : '0;
      end
    end else begin : g_ram
      always_ff @(posedge clk) begin
        if (wrEn) tbl[wrAddr[GROUP +: GA_W]][wrAddr[GROUP-1:0]] <= wrData;
      end
    end
  endgenerate

  always_comb begin
    for (int l = 0; l < BPC; l++)
      for (int g = 0; g < NG; g++)
        rdData[l][g] = tbl[g][rdAddr[l][g]];
  end

endmodule

// File: rtl/dafir_dp.sv
module dafir_dp
  import dafir_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 12,
  parameter int GROUP  = 8,
  parameter int BPC    = 2,
  parameter int RATIO  = 4,
  parameter int SIGNED = 1,
  localparam int NG    = (TAPS + GROUP - 1) / GROUP,
  localparam int LUT_W = COEF_W + $clog2(GROUP + 1),
  localparam int OUT_W = IN_W + COEF_W + $clog2(TAPS) - 1,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  dafirStrobe_t       strobe,
  input  logic [CNT_W-1:0]   stepIdx,
  input  logic [IN_W-1:0]    inData,
  output logic [GROUP-1:0]   rdAddr [BPC][NG],
  input  logic [LUT_W-1:0]   rdData [BPC][NG],
  output logic               outValid,
  output logic [OUT_W-1:0]   outData
);

  logic [IN_W-1:0]  taps [TAPS];
  logic [OUT_W-1:0] acc;
  logic [OUT_W-1:0] contrib;

  function automatic logic selBit(logic [IN_W-1:0] v, int b);
    logic r;
    r = 1'b0;
    for (int k = 0; k < IN_W; k++)
      if (k == b) r = v[k];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) taps[k] <= '0;
    end else if (strobe.load) begin
      taps[0] <= inData;
      for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  // Gather one bit per tap into the group table addresses
  always_comb begin
    int b;
    for (int l = 0; l < BPC; l++)
      for (int g = 0; g < NG; g++)
        rdAddr[l][g] = '0;
    for (int l = 0; l < BPC; l++) begin
      b = int'(stepIdx) * BPC + l;
      for (int k = 0; k < TAPS; k++)
        rdAddr[l][k / GROUP][k % GROUP] = selBit(taps[k], b);
    end
  end

  // Sum the groups, weight by bit position, negate the sign position
  always_comb begin
    int b;
    logic [OUT_W-1:0] part;
    contrib = '0;
    for (int l = 0; l < BPC; l++) begin
      b = int'(stepIdx) * BPC + l;
      part = '0;
      for (int g = 0; g < NG; g++) begin
        if (SIGNED != 0) part += OUT_W'($signed(rdData[l][g]));
        else             part += OUT_W'(rdData[l][g]);
      end
      if (b < IN_W) begin
        if (SIGNED != 0 && b == IN_W - 1) contrib -= part << b;
        else                              contrib += part << b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.done;
      if (strobe.done) outData <= acc + contrib;
      if (strobe.load)     acc <= '0;
      else if (strobe.run) acc <= acc + contrib;
    end
  end

endmodule

// File: rtl/dafir.sv
module dafir
  import dafir_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int COEF_W     = 8,
  parameter int TAPS       = 12,
  parameter int GROUP      = 8,
  parameter int RATIO      = 4,
  parameter int BPC        = 2,
  parameter int SIGNED     = 1,
  parameter int FIXED_COEF = 1,
  parameter logic [TAPS*COEF_W-1:0] COEFS = 96'hFD5A8021_64B30580_40FF7F80,
  localparam int NG    = (TAPS + GROUP - 1) / GROUP,
  localparam int GA_W  = (NG > 1) ? $clog2(NG) : 1,
  localparam int LUT_W = COEF_W + $clog2(GROUP + 1),
  localparam int OUT_W = IN_W + COEF_W + $clog2(TAPS) - 1,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [IN_W-1:0]       inData,
  input  logic                  wrEn,
  input  logic [GA_W+GROUP-1:0] wrAddr,
  input  logic [LUT_W-1:0]      wrData,
  output logic                  outValid,
  output logic [OUT_W-1:0]      outData
);

  generate
    if (RATIO < 2 || RATIO * BPC < IN_W) begin : g_badCfg
      $error("dafir: RATIO must exceed 1 and RATIO*BPC must cover IN_W");
    end
  endgenerate

  dafirStrobe_t     ctrlStrobe;
  logic [CNT_W-1:0] stepIdx;
  logic [GROUP-1:0] rdAddr [BPC][NG];
  logic [LUT_W-1:0] rdData [BPC][NG];

  dafir_ctrl #(.RATIO(RATIO)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(ctrlStrobe), .stepIdx(stepIdx)
  );

  dafir_lut #(
    .IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .GROUP(GROUP), .BPC(BPC),
    .SIGNED(SIGNED), .FIXED_COEF(FIXED_COEF), .COEFS(COEFS)
  ) u_lut (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  dafir_dp #(
    .IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .GROUP(GROUP), .BPC(BPC),
    .RATIO(RATIO), .SIGNED(SIGNED)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(ctrlStrobe), .stepIdx(stepIdx),
    .inData(inData), .rdAddr(rdAddr), .rdData(rdData),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/dafir_checker.sv
module dafir_checker
  import dafir_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int OUT_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input dafirStrobe_t     strobe
);

  int gap;

  always_ff @(posedge clk) begin
    if (rst)           gap <= RATIO;
    else if (outValid) gap <= 0;
    else if (gap < RATIO) gap <= gap + 1;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) outValid |=> !outValid); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) !outValid |-> $stable(outData)); // R5
  AST_DONE_TO_OUT: assert property (@(posedge clk) disable iff (rst) strobe.done |=> outValid); // R5
  AST_LOAD_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) strobe.load |-> inValid); // R4
  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (rst) outValid |-> gap >= RATIO - 1); // R4

endmodule

bind dafir dafir_checker #(.RATIO(RATIO), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid),
  .outData(outData), .strobe(ctrlStrobe)
);

// File: tb/dafir_bench.sv
`timescale 1ns/1ps
module dafir_bench;

  localparam logic [95:0] COEF_S = 96'hFD5A8021_64B30580_40FF7F80;  // 12 signed taps
  localparam logic [87:0] COEF_U = 88'hB4_07_FA_40_03_63_11_C8_80_01_FF; // 11 unsigned taps
  localparam int NT[2] = '{12, 11};
  localparam int RT[2] = '{4, 8};
  localparam int MASK = 32'h7FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic wrEn = 1'b0;
  logic [8:0]  wrAddrS = '0;
  logic [11:0] wrDataS = '0;
  logic [5:0]  wrAddrU = '0;
  logic [10:0] wrDataU = '0;
  logic outValidS, outValidU;
  logic [18:0] outDataS, outDataU;

  always #4 clk = ~clk;

  dafir #(.TAPS(12), .GROUP(8), .RATIO(4), .BPC(2), .SIGNED(1), .FIXED_COEF(1),
          .COEFS(COEF_S)) u_dafir (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .wrEn(wrEn), .wrAddr(wrAddrS), .wrData(wrDataS),
    .outValid(outValidS), .outData(outDataS));

  dafir #(.TAPS(11), .GROUP(4), .RATIO(8), .BPC(1), .SIGNED(0), .FIXED_COEF(0),
          .COEFS(COEF_U)) u_dafirUns (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .wrEn(wrEn), .wrAddr(wrAddrU), .wrData(wrDataU),
    .outValid(outValidU), .outData(outDataU));

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int hist[2][12];
  int rcnt[2];
  int pend[2];
  int expOut[2];
  bit expVal[2];

  function automatic int coefOf(int d, int k);
    if (d == 0) return int'($signed(COEF_S[k*8 +: 8]));
    return int'(COEF_U[k*8 +: 8]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 12; k++) hist[d][k] = 0;
      rcnt[d] = -1; pend[d] = 0; expOut[d] = 0; expVal[d] = 0;
    end
  endtask

  task automatic modelStep();
    bit fin, acc;
    int s;
    for (int d = 0; d < 2; d++) begin
      fin = (rcnt[d] == RT[d] - 1);
      acc = inValid && (rcnt[d] < 0 || fin);
      expVal[d] = fin;
      if (fin) begin expOut[d] = pend[d]; rcnt[d] = -1; end
      else if (rcnt[d] >= 0) rcnt[d]++;
      if (acc) begin
        for (int k = 11; k > 0; k--) hist[d][k] = hist[d][k-1];
        hist[d][0] = (d == 0) ? int'($signed(inData)) : int'(inData);
        s = 0;
        for (int k = 0; k < NT[d]; k++) s += coefOf(d, k) * hist[d][k];
        pend[d] = s;
        rcnt[d] = 0;
      end
    end
  endtask

  task automatic compare();
    chk(outValidS == expVal[0], "R4 R5 signed outValid", int'(outValidS), int'(expVal[0]));
    chk(outValidU == expVal[1], "R4 R5 unsigned outValid", int'(outValidU), int'(expVal[1]));
    chk(int'(outDataS) == (expOut[0] & MASK), "R1 R3 R6 R7 R9 signed outData",
        int'(outDataS), expOut[0] & MASK);
    chk(int'(outDataU) == (expOut[1] & MASK), "R1 R2 R6 R8 R9 unsigned outData",
        int'(outDataU), expOut[1] & MASK);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) modelReset(); else modelStep();
    @(negedge clk);
    if (!rst) compare();
  endtask

  task automatic send(logic [7:0] v, int idle);
    inValid = 1'b1; inData = v; step();
    inValid = 1'b0;
    for (int i = 0; i < idle; i++) step();
  endtask

  function automatic int uWord(int g, int a);
    int s = 0;
    for (int j = 0; j < 4; j++)
      if (g*4 + j < 11 && ((a >> j) & 1) == 1) s += coefOf(1, g*4 + j);
    return s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    modelReset();
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    step();
    // R10: reset state at the ports
    chk(outValidS == 1'b0 && outValidU == 1'b0, "R10 outValid after reset",
        int'(outValidS) + int'(outValidU), 0);
    chk(outDataS == '0 && outDataU == '0, "R10 outData after reset",
        int'(outDataS) + int'(outDataU), 0);
    chk($bits(outDataS) == 19 && $bits(outDataU) == 19, "R1 output width", $bits(outDataS), 19);

    // R8: load unsigned tables; R7: garbage writes to the constant-table filter
    wrEn = 1'b1;
    for (int g = 0; g < 3; g++)
      for (int a = 0; a < 16; a++) begin
        wrAddrU = {2'(g), 4'(a)};
        wrDataU = 11'(uWord(g, a));
        wrAddrS = 9'($urandom);
        wrDataS = 12'($urandom);
        step();
      end
    wrEn = 1'b0;

    // R6 R9: impulse shows every coefficient in tap order
    send(8'h01, 9);
    for (int i = 0; i < 13; i++) send(8'h00, 9);

    // R3 R2: full-scale values
    for (int i = 0; i < 14; i++) send(8'h80, 8);
    for (int i = 0; i < 14; i++) send(8'hFF, 8);
    send(8'h7F, 8); send(8'h00, 8); send(8'h80, 8); send(8'h7F, 8);

    // R4: inValid held high, strobes during processing must be ignored
    inValid = 1'b1;
    for (int i = 0; i < 300; i++) begin inData = 8'($urandom); step(); end
    inData = 8'h80;
    for (int i = 0; i < 120; i++) step();
    inValid = 1'b0;

    // Random strobes and data
    for (int i = 0; i < 1500; i++) begin
      inValid = ($urandom % 3) != 0;
      inData = 8'($urandom);
      step();
    end
    inValid = 1'b0;
    for (int i = 0; i < 20; i++) step();
    summary();
  end

endmodule